// File: doc/BRIEF.md
# I2C Master FIFO Watermark and Status-Flag Unit

This block sits between the register interface of an I2C master and its bus engine. It holds a transmit FIFO of command/data entries that software fills and the bus engine drains, and a receive FIFO of bytes that the bus engine fills and software drains. It turns the fill level of each FIFO into a data flag by comparing it against a programmable watermark. It turns the bus engine's single-cycle events (stop seen, NACK seen, arbitration lost) into sticky flags that software clears by writing 1. A masked OR of the flags drives one interrupt line.

Software reaches the unit through a simple word register port. The port has a write strobe, a read strobe, a byte offset and 32-bit data, and read data is combinational. A read-only word reports both FIFO depths as log2 values, and a control word holds the watermarks. An occupancy word reports the fill levels. A control register can enable the master, hold the unit in soft reset, or empty either FIFO in one write. The register offsets are 0x00 depth info, 0x04 control, 0x08 status, 0x0C interrupt enable, 0x10 watermarks, 0x14 occupancy, 0x18 transmit data and 0x1C receive data.

Top module: `i2c_fifo_flags`

## Requirements
- R1: The word at offset 0x00 reads the transmit depth log2 in bits 3:0 and the receive depth log2 in bits 11:8; all other bits read 0 and writes have no effect.
- R2: The word at 0x10 holds the transmit watermark in bits TX_LOG2-1:0 and the receive watermark in bits starting at 16; other bits read 0; both reset to 0.
- R3: The word at 0x14 reads the transmit FIFO occupancy in bits 7:0 and the receive FIFO occupancy in bits 23:16.
- R4: A write to 0x18 appends bits 10:0 to the transmit FIFO unless it is full, in which case the write is dropped. eng_tx_avail shows that the FIFO is not empty, eng_tx_data presents the oldest entry, and eng_tx_pop removes it.
- R5: A read of 0x1C returns the oldest receive byte in bits 7:0 and removes it. When the receive FIFO is empty the read returns 0x00004000 (bit 14 set) and removes nothing. An eng_rx_push into a full receive FIFO is dropped.
- R6: Status bit 0 is 1 while the transmit occupancy is at most the transmit watermark. Status bit 1 is 1 while the receive occupancy exceeds the receive watermark.
- R7: Status bits 9 (stop), 10 (NACK) and 11 (arbitration lost) are set by a one-cycle pulse on evt_stop, evt_nack and evt_arb and stay set. Writing 1 to a bit at 0x08 clears it, while writing 0 leaves it. An event in the same cycle as its clearing write leaves the flag set. Bits 24 and 25 follow busy_master and busy_bus. All other status bits read 0.
- R8: The enable word at 0x0C keeps only bits 0, 1, 9 and 10. irq is 1 exactly when one of those enabled status bits is 1.
- R9: In the control word at 0x04, bit 0 drives ctl_enable and bit 1 is the soft reset; both read back. Writing 1 to bit 8 or bit 9 empties the transmit or receive FIFO at that clock edge, and a push into that FIFO in the same cycle is dropped. Bits 8 and 9 always read 0.
- R10: While the soft-reset bit is 1, both FIFOs are held empty and the three sticky flags are held clear. Watermarks, interrupt enables and the control word keep their values.
- R11: After synchronous reset both FIFOs are empty, every writable register is 0, the status reads 0x00000001 plus the busy bits, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at 0x1C) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| eng_tx_avail | output | 1 | Transmit FIFO is not empty |
| eng_tx_data | output | 11 | Oldest transmit entry |
| eng_tx_pop | input | 1 | Bus engine consumes the oldest transmit entry |
| eng_rx_push | input | 1 | Bus engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| evt_stop | input | 1 | One-cycle pulse: stop condition seen |
| evt_nack | input | 1 | One-cycle pulse: NACK seen |
| evt_arb | input | 1 | One-cycle pulse: arbitration lost |
| busy_master | input | 1 | Master busy level |
| busy_bus | input | 1 | Bus busy level |
| ctl_enable | output | 1 | Master enable bit from the control word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with TX_LOG2 = 2 and RX_LOG2 = 2, so each FIFO holds four entries. A few writes or pushes are enough to reach a full FIFO and the dropped fifth entry. With the watermarks at 2 and 1, both sides of each comparison can be crossed one entry at a time. The receive watermark field is then two bits wide, which shows that bits written above the field are discarded. A behavioural queue model follows every clock and checks the interrupt, the engine-side head and the enable output on each cycle.

// File: rtl/i2c_ff_pkg.sv
package i2c_ff_pkg;

    localparam int REG_W  = 32;
    localparam int CMD_W  = 11;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 5;

    localparam logic [OFS_W-1:0] A_INFO  = 5'h00;
    localparam logic [OFS_W-1:0] A_CTRL  = 5'h04;
    localparam logic [OFS_W-1:0] A_STAT  = 5'h08;
    localparam logic [OFS_W-1:0] A_IEN   = 5'h0C;
    localparam logic [OFS_W-1:0] A_WMARK = 5'h10;
    localparam logic [OFS_W-1:0] A_OCC   = 5'h14;
    localparam logic [OFS_W-1:0] A_TXD   = 5'h18;
    localparam logic [OFS_W-1:0] A_RXD   = 5'h1C;

    localparam int C_EN    = 0;
    localparam int C_SRST  = 1;
    localparam int C_TXFL  = 8;
    localparam int C_RXFL  = 9;

    localparam int S_TXREQ = 0;
    localparam int S_RXRDY = 1;
    localparam int S_EVT0  = 9;
    localparam int N_EVT   = 3;
    localparam int S_MBUSY = 24;
    localparam int S_BBUSY = 25;

    localparam int RX_EMPTY_BIT = 14;
    localparam int RXWM_LSB     = 16;
    localparam int RXOCC_LSB    = 16;
    localparam int OCC_W        = 8;

    typedef struct packed {
        logic srst;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_stat;
        logic wr_ien;
        logic wr_wmark;
        logic wr_txd;
        logic rd_rxd;
    } acc_t;

    function automatic acc_t decode_access(input logic wr, input logic rd,
                                           input logic hit, input logic [OFS_W-1:0] a);
        acc_t d;
        d.wr_ctrl  = hit && wr && (a == A_CTRL);
        d.wr_stat  = hit && wr && (a == A_STAT);
        d.wr_ien   = hit && wr && (a == A_IEN);
        d.wr_wmark = hit && wr && (a == A_WMARK);
        d.wr_txd   = hit && wr && (a == A_TXD);
        d.rd_rxd   = hit && rd && (a == A_RXD);
        return d;
    endfunction

endpackage

// File: rtl/i2c_ff_fifo.sv
module i2c_ff_fifo #(
    parameter int W    = 8,
    parameter int LOG2 = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LOG2:0] count,
    output logic          empty
);
    localparam int DEPTH = 1 << LOG2;

    logic [W-1:0]      mem [DEPTH];
    logic [LOG2-1:0]   wp, rp;
    logic [LOG2:0]     cnt;
    logic              full, do_push, do_pop;

    assign full    = (cnt == (LOG2+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (LOG2+1)'(do_push) - (LOG2+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !rst) mem[wp] <= wdata;
    end

    assign rdata = mem[rp];
    assign count = cnt;

endmodule

// File: rtl/i2c_ff_flags.sv
module i2c_ff_flags
    import i2c_ff_pkg::*;
#(
    parameter int TX_LOG2 = 2,
    parameter int RX_LOG2 = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_evt,
    input  logic [TX_LOG2:0]   tx_cnt,
    input  logic [RX_LOG2:0]   rx_cnt,
    input  logic [TX_LOG2-1:0] tx_wm,
    input  logic [RX_LOG2-1:0] rx_wm,
    input  logic [N_EVT-1:0]   evt,
    input  logic               wr_stat,
    input  logic [N_EVT-1:0]   w1c,
    input  logic               wr_ien,
    input  logic [3:0]         ien_wdata,
    input  logic               busy_m,
    input  logic               busy_b,
    output logic [REG_W-1:0]   stat_word,
    output logic [REG_W-1:0]   ien_word,
    output logic [N_EVT-1:0]   sticky,
    output logic [3:0]         ien_bits,
    output logic               irq
);
    logic tx_req, rx_rdy;
    logic [3:0] ien_q;

    assign tx_req = (tx_cnt <= {1'b0, tx_wm});
    assign rx_rdy = (rx_cnt >  {1'b0, rx_wm});

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        logic q;
        always_ff @(posedge clk) begin
            if (rst || clr_evt)         q <= 1'b0;
            else if (evt[i])            q <= 1'b1;
            else if (wr_stat && w1c[i]) q <= 1'b0;
        end
        assign sticky[i] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)         ien_q <= '0;
        else if (wr_ien) ien_q <= ien_wdata;
    end

    always_comb begin
        stat_word                 = '0;
        stat_word[S_TXREQ]        = tx_req;
        stat_word[S_RXRDY]        = rx_rdy;
        stat_word[S_EVT0 +: N_EVT] = sticky;
        stat_word[S_MBUSY]        = busy_m;
        stat_word[S_BBUSY]        = busy_b;
    end

    always_comb begin
        ien_word             = '0;
        ien_word[S_TXREQ]    = ien_q[0];
        ien_word[S_RXRDY]    = ien_q[1];
        ien_word[S_EVT0]     = ien_q[2];
        ien_word[S_EVT0 + 1] = ien_q[3];
    end

    assign irq = (tx_req & ien_q[0]) | (rx_rdy & ien_q[1]) |
                 (sticky[0] & ien_q[2]) | (sticky[1] & ien_q[3]);
    assign ien_bits = ien_q;

endmodule

// File: rtl/i2c_ff_regs.sv
module i2c_ff_regs
    import i2c_ff_pkg::*;
#(
    parameter int TX_LOG2 = 2,
    parameter int RX_LOG2 = 2,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [REG_W-1:0]   stat_word,
    input  logic [REG_W-1:0]   ien_word,
    input  logic [TX_LOG2:0]   tx_cnt,
    input  logic [RX_LOG2:0]   rx_cnt,
    input  logic               rx_empty,
    input  logic [BYTE_W-1:0]  rx_head,
    output acc_t               acc,
    output ctrl_t              ctrl,
    output logic               clr_tx,
    output logic               clr_rx,
    output logic [TX_LOG2-1:0] tx_wm,
    output logic [RX_LOG2-1:0] rx_wm,
    output logic [REG_W-1:0]   reg_rdata
);
    logic              hit;
    logic [OFS_W-1:0]  ofs;
    ctrl_t             ctrl_q;
    logic [TX_LOG2-1:0] tx_wm_q;
    logic [RX_LOG2-1:0] rx_wm_q;
    logic              unused_wdata;

    assign hit = ((reg_addr >> OFS_W) == '0);
    assign ofs = reg_addr[OFS_W-1:0];
    assign acc = decode_access(reg_wr, reg_rd, hit, ofs);
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            tx_wm_q <= '0;
            rx_wm_q <= '0;
        end else begin
            if (acc.wr_ctrl) begin
                ctrl_q.enable <= reg_wdata[C_EN];
                ctrl_q.srst   <= reg_wdata[C_SRST];
            end
            if (acc.wr_wmark) begin
                tx_wm_q <= reg_wdata[TX_LOG2-1:0];
                rx_wm_q <= reg_wdata[RXWM_LSB +: RX_LOG2];
            end
        end
    end

    assign clr_tx = (acc.wr_ctrl && reg_wdata[C_TXFL]) || ctrl_q.srst;
    assign clr_rx = (acc.wr_ctrl && reg_wdata[C_RXFL]) || ctrl_q.srst;
    assign ctrl   = ctrl_q;
    assign tx_wm  = tx_wm_q;
    assign rx_wm  = rx_wm_q;

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (ofs)
                A_INFO: begin
                    reg_rdata[3:0]  = 4'(TX_LOG2);
                    reg_rdata[11:8] = 4'(RX_LOG2);
                end
                A_CTRL: begin
                    reg_rdata[C_EN]   = ctrl_q.enable;
                    reg_rdata[C_SRST] = ctrl_q.srst;
                end
                A_STAT:  reg_rdata = stat_word;
                A_IEN:   reg_rdata = ien_word;
                A_WMARK: begin
                    reg_rdata[TX_LOG2-1:0]         = tx_wm_q;
                    reg_rdata[RXWM_LSB +: RX_LOG2] = rx_wm_q;
                end
                A_OCC: begin
                    reg_rdata[OCC_W-1:0]           = OCC_W'(tx_cnt);
                    reg_rdata[RXOCC_LSB +: OCC_W]  = OCC_W'(rx_cnt);
                end
                A_RXD: begin
                    if (rx_empty) reg_rdata[RX_EMPTY_BIT]   = 1'b1;
                    else          reg_rdata[BYTE_W-1:0]     = rx_head;
                end
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/i2c_fifo_flags.sv
module i2c_fifo_flags
    import i2c_ff_pkg::*;
#(
    parameter int TX_LOG2 = 2,
    parameter int RX_LOG2 = 2,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              eng_tx_avail,
    output logic [CMD_W-1:0]  eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [BYTE_W-1:0] eng_rx_data,
    input  logic              evt_stop,
    input  logic              evt_nack,
    input  logic              evt_arb,
    input  logic              busy_master,
    input  logic              busy_bus,
    output logic              ctl_enable,
    output logic              irq
);
    acc_t               acc;
    ctrl_t              ctrl;
    logic               clr_tx, clr_rx;
    logic [TX_LOG2-1:0] tx_wm;
    logic [RX_LOG2-1:0] rx_wm;
    logic [TX_LOG2:0]   tx_cnt;
    logic [RX_LOG2:0]   rx_cnt;
    logic               tx_empty, rx_empty;
    logic [BYTE_W-1:0]  rx_head;
    logic [REG_W-1:0]   stat_word, ien_word;
    logic [N_EVT-1:0]   sticky;
    logic [3:0]         ien_bits;
    logic               srst_q;

    i2c_ff_regs #(.TX_LOG2(TX_LOG2), .RX_LOG2(RX_LOG2), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .stat_word(stat_word), .ien_word(ien_word),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_empty(rx_empty), .rx_head(rx_head),
        .acc(acc), .ctrl(ctrl), .clr_tx(clr_tx), .clr_rx(clr_rx),
        .tx_wm(tx_wm), .rx_wm(rx_wm), .reg_rdata(reg_rdata)
    );

    i2c_ff_fifo #(.W(CMD_W), .LOG2(TX_LOG2)) u_txq (
        .clk(clk), .rst(rst), .clr(clr_tx),
        .push(acc.wr_txd), .wdata(reg_wdata[CMD_W-1:0]),
        .pop(eng_tx_pop), .rdata(eng_tx_data),
        .count(tx_cnt), .empty(tx_empty)
    );

    i2c_ff_fifo #(.W(BYTE_W), .LOG2(RX_LOG2)) u_rxq (
        .clk(clk), .rst(rst), .clr(clr_rx),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(acc.rd_rxd), .rdata(rx_head),
        .count(rx_cnt), .empty(rx_empty)
    );

    i2c_ff_flags #(.TX_LOG2(TX_LOG2), .RX_LOG2(RX_LOG2)) u_flags (
        .clk(clk), .rst(rst), .clr_evt(ctrl.srst),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_wm(tx_wm), .rx_wm(rx_wm),
        .evt({evt_arb, evt_nack, evt_stop}),
        .wr_stat(acc.wr_stat), .w1c(reg_wdata[S_EVT0 +: N_EVT]),
        .wr_ien(acc.wr_ien),
        .ien_wdata({reg_wdata[S_EVT0 + 1], reg_wdata[S_EVT0], reg_wdata[S_RXRDY], reg_wdata[S_TXREQ]}),
        .busy_m(busy_master), .busy_b(busy_bus),
        .stat_word(stat_word), .ien_word(ien_word),
        .sticky(sticky), .ien_bits(ien_bits), .irq(irq)
    );

    assign eng_tx_avail = !tx_empty;
    assign ctl_enable   = ctrl.enable;
    assign srst_q       = ctrl.srst;

endmodule

// File: rtl/i2c_ff_chk.sv
module i2c_ff_chk
    import i2c_ff_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              eng_tx_avail,
    input logic              evt_nack,
    input logic              ctl_enable,
    input logic              irq,
    input logic              srst_q,
    input logic [N_EVT-1:0]  sticky,
    input logic [3:0]        ien_bits
);
    logic wr_ctrl, wr_txd, unused_wdata;
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_txd  = reg_wr && (reg_addr == ADDR_W'(A_TXD));
    assign unused_wdata = ^reg_wdata;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!eng_tx_avail && !irq && sticky == '0)); // R11
    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_txd && !srst_q) |=> eng_tx_avail); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && reg_wdata[C_TXFL]) |=> !eng_tx_avail); // R9
    AST_ENABLE_TRACKS: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctl_enable == $past(reg_wdata[C_EN]))); // R9
    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
        (evt_nack && !srst_q) |=> sticky[1]); // R7
    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ien_bits == '0) |-> !irq); // R8
    AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (!eng_tx_avail && sticky == '0)); // R10

endmodule

bind i2c_fifo_flags i2c_ff_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .eng_tx_avail(eng_tx_avail), .evt_nack(evt_nack),
    .ctl_enable(ctl_enable), .irq(irq), .srst_q(srst_q),
    .sticky(sticky), .ien_bits(ien_bits)
);

// File: tb/i2c_fifo_flags_bench.sv
module i2c_fifo_flags_bench;
    import i2c_ff_pkg::*;

    localparam int TXL = 2;
    localparam int RXL = 2;
    localparam int TXD = 1 << TXL;
    localparam int RXD = 1 << RXL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        reg_wr = 0, reg_rd = 0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_tx_avail;
    logic [10:0] eng_tx_data;
    logic        eng_tx_pop = 0, eng_rx_push = 0;
    logic [7:0]  eng_rx_data = '0;
    logic        evt_stop = 0, evt_nack = 0, evt_arb = 0;
    logic        busy_master = 0, busy_bus = 0;
    logic        ctl_enable, irq;

    i2c_fifo_flags #(.TX_LOG2(TXL), .RX_LOG2(RXL), .ADDR_W(5)) u_i2c_fifo_flags (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_avail(eng_tx_avail), .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .evt_stop(evt_stop), .evt_nack(evt_nack), .evt_arb(evt_arb),
        .busy_master(busy_master), .busy_bus(busy_bus),
        .ctl_enable(ctl_enable), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model
    logic [10:0] txq[$];
    logic [7:0]  rxq[$];
    int          m_txwm, m_rxwm;
    bit          m_en, m_sr;
    bit [2:0]    m_st;
    bit [3:0]    m_ien;
    bit          fl_tx, fl_rx, ev;
    int          txs, rxs;

    function automatic bit m_txreq(); return txq.size() <= m_txwm; endfunction
    function automatic bit m_rxrdy(); return rxq.size() > m_rxwm;  endfunction
    function automatic bit m_irq();
        return (m_txreq() & m_ien[0]) | (m_rxrdy() & m_ien[1]) |
               (m_st[0] & m_ien[2]) | (m_st[1] & m_ien[3]);
    endfunction

    function automatic logic [31:0] mread(input logic [4:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            A_INFO:  begin r[3:0] = 4'(TXL); r[11:8] = 4'(RXL); end
            A_CTRL:  begin r[0] = m_en; r[1] = m_sr; end
            A_STAT:  begin
                r[0] = m_txreq(); r[1] = m_rxrdy();
                r[11:9] = m_st; r[24] = busy_master; r[25] = busy_bus;
            end
            A_IEN:   begin r[0] = m_ien[0]; r[1] = m_ien[1]; r[9] = m_ien[2]; r[10] = m_ien[3]; end
            A_WMARK: begin r[15:0] = 16'(m_txwm); r[31:16] = 16'(m_rxwm); end
            A_OCC:   begin r[7:0] = 8'(txq.size()); r[23:16] = 8'(rxq.size()); end
            A_RXD:   begin if (rxq.size() == 0) r[14] = 1'b1; else r[7:0] = rxq[0]; end
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            txq.delete(); rxq.delete();
            m_txwm = 0; m_rxwm = 0; m_en = 0; m_sr = 0; m_st = '0; m_ien = '0;
        end else begin
            fl_tx = (reg_wr && reg_addr == A_CTRL && reg_wdata[8]) || m_sr;
            fl_rx = (reg_wr && reg_addr == A_CTRL && reg_wdata[9]) || m_sr;
            txs = txq.size();
            rxs = rxq.size();
            if (fl_tx) txq.delete();
            else begin
                if (eng_tx_pop && txs > 0) void'(txq.pop_front());
                if (reg_wr && reg_addr == A_TXD && txs < TXD) txq.push_back(reg_wdata[10:0]);
            end
            if (fl_rx) rxq.delete();
            else begin
                if (reg_rd && reg_addr == A_RXD && rxs > 0) void'(rxq.pop_front());
                if (eng_rx_push && rxs < RXD) rxq.push_back(eng_rx_data);
            end
            for (int i = 0; i < 3; i++) begin
                ev = (i == 0) ? evt_stop : (i == 1) ? evt_nack : evt_arb;
                if (m_sr) m_st[i] = 1'b0;
                else if (ev) m_st[i] = 1'b1;
                else if (reg_wr && reg_addr == A_STAT && reg_wdata[9+i]) m_st[i] = 1'b0;
            end
            if (reg_wr && reg_addr == A_CTRL) begin m_en = reg_wdata[0]; m_sr = reg_wdata[1]; end
            if (reg_wr && reg_addr == A_WMARK) begin
                m_txwm = int'(reg_wdata[TXL-1:0]);
                m_rxwm = int'(reg_wdata[16 +: RXL]);
            end
            if (reg_wr && reg_addr == A_IEN)
                m_ien = {reg_wdata[10], reg_wdata[9], reg_wdata[1], reg_wdata[0]};
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            chk("R8 irq", {31'b0, irq}, {31'b0, m_irq()});
            chk("R4 avail", {31'b0, eng_tx_avail}, {31'b0, txq.size() > 0});
            if (txq.size() > 0) chk("R4 head", {21'b0, eng_tx_data}, {21'b0, txq[0]});
            chk("R9 enable", {31'b0, ctl_enable}, {31'b0, m_en});
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rdx(input string tag, input logic [4:0] a, input logic [31:0] exp);
        reg_rd = 1; reg_addr = a;
        #2;
        chk(tag, reg_rdata, exp);
        chk({tag, " model"}, reg_rdata, mread(a));
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic txpop();
        eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
    endtask

    task automatic rxpush(input logic [7:0] d);
        eng_rx_push = 1; eng_rx_data = d; @(negedge clk); eng_rx_push = 0;
    endtask

    task automatic pulse(input int which);
        if (which == 0) evt_stop = 1; else if (which == 1) evt_nack = 1; else evt_arb = 1;
        @(negedge clk);
        evt_stop = 0; evt_nack = 0; evt_arb = 0;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state, R1 depth word
        rdx("R1 info", A_INFO, 32'h0000_0202);
        rdx("R11 status", A_STAT, 32'h0000_0001);
        rdx("R11 ctrl", A_CTRL, 32'h0);
        rdx("R11 ien", A_IEN, 32'h0);
        rdx("R11 wmark", A_WMARK, 32'h0);
        rdx("R11 occ", A_OCC, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        wr(A_INFO, 32'hFFFF_FFFF);
        rdx("R1 info ro", A_INFO, 32'h0000_0202);
        rdx("R5 empty read", A_RXD, 32'h0000_4000);
        // R7 busy bits
        busy_master = 1; busy_bus = 1; @(negedge clk);
        rdx("R7 busy", A_STAT, 32'h0300_0001);
        busy_master = 0; busy_bus = 0;
        // R2 watermarks
        wr(A_WMARK, 32'hFFFF_FFFF);
        rdx("R2 mask", A_WMARK, 32'h0003_0003);
        wr(A_WMARK, 32'h0001_0002);
        rdx("R2 value", A_WMARK, 32'h0001_0002);
        // R4 fill transmit FIFO past full
        for (int i = 0; i < 5; i++) wr(A_TXD, 32'h500 + 32'(i * 3));
        rdx("R3 R4 occ full", A_OCC, 32'h0000_0004);
        rdx("R6 txreq off", A_STAT, 32'h0);
        txpop();
        rdx("R6 txreq at wm+1", A_STAT, 32'h0);
        txpop();
        rdx("R6 txreq at wm", A_STAT, 32'h1);
        chk("R4 head order", {21'b0, eng_tx_data}, 32'h506);
        // R5 and R6 receive side
        rxpush(8'h11);
        rdx("R6 rxrdy at wm", A_STAT, 32'h1);
        rxpush(8'h22);
        rdx("R6 rxrdy above wm", A_STAT, 32'h3);
        rxpush(8'h33); rxpush(8'h44); rxpush(8'h55);
        rdx("R3 R5 occ", A_OCC, 32'h0004_0002);
        rdx("R5 rx0", A_RXD, 32'h11);
        rdx("R5 rx1", A_RXD, 32'h22);
        rdx("R5 rx2", A_RXD, 32'h33);
        rdx("R5 rx3", A_RXD, 32'h44);
        rdx("R5 rx empty", A_RXD, 32'h4000);
        // R7 sticky flags
        pulse(1);
        rdx("R7 nack set", A_STAT, 32'h401);
        wr(A_STAT, 32'h0);
        rdx("R7 zero write", A_STAT, 32'h401);
        wr(A_STAT, 32'h400);
        rdx("R7 w1c", A_STAT, 32'h001);
        pulse(2);
        evt_stop = 1; wr(A_STAT, 32'h200); evt_stop = 0;
        rdx("R7 set wins", A_STAT, 32'hA01);
        wr(A_STAT, 32'h7F00);
        rdx("R7 clear all", A_STAT, 32'h001);
        // R8 interrupt mask
        wr(A_IEN, 32'hFFFF_FFFF);
        rdx("R8 ien bits", A_IEN, 32'h603);
        chk("R8 irq txreq", {31'b0, irq}, 32'h1);
        wr(A_IEN, 32'h400);
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        pulse(1);
        chk("R8 irq nack", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h400);
        chk("R8 irq cleared", {31'b0, irq}, 32'h0);
        // R9 flush and enable
        rxpush(8'h66);
        eng_rx_push = 1; eng_rx_data = 8'h77;
        wr(A_CTRL, 32'h301);
        eng_rx_push = 0;
        rdx("R9 flush occ", A_OCC, 32'h0);
        rdx("R9 ctrl rb", A_CTRL, 32'h1);
        chk("R9 enable pin", {31'b0, ctl_enable}, 32'h1);
        // R10 soft reset
        wr(A_TXD, 32'h123);
        wr(A_CTRL, 32'h3);
        wr(A_TXD, 32'h124);
        rxpush(8'h88);
        pulse(1);
        rdx("R10 occ held", A_OCC, 32'h0);
        rdx("R10 flags held", A_STAT, 32'h1);
        rdx("R10 wmark kept", A_WMARK, 32'h0001_0002);
        rdx("R10 ien kept", A_IEN, 32'h400);
        wr(A_CTRL, 32'h1);
        wr(A_TXD, 32'h125);
        rdx("R10 release", A_OCC, 32'h1);
        chk("R4 head after release", {21'b0, eng_tx_data}, 32'h125);
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule